// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor that finishes one instruction per clock cycle. Instructions are 32 bits wide and registers are 64 bits wide. It runs nine instructions: register add, subtract, AND and OR; doubleword load and store with a signed 9-bit byte offset; branch when a register is zero; an unconditional relative branch; and a move of a 16-bit zero-extended constant. Decode, operand fetch, the ALU, the memory read and next-PC selection are all combinational. The program counter, the register file and the data memory change only on the rising clock edge.

The core holds its own instruction memory and data memory. They are filled over a valid/ready load stream while the core is idle. The `run` input starts execution from address 0; dropping `run` parks the core back at address 0. While the core runs, it reports each register write-back and each store on its trace outputs, in the same cycle the instruction executes. The load stream applies back-pressure through `ld_ready`. `ld_ready` is high only while `run` is low. A word offered while `ld_ready` is low is not taken, and the producer must hold it until a cycle where both `ld_valid` and `ld_ready` are high.

Top module: `sc_core`

## Requirements
- R1: While `run` is low, `ld_ready` is 1, `wb_valid` and `st_valid` are 0, and the PC returns to 0 on the next edge. While `run` is high, `ld_ready` is 0.
- R2: Register instructions use opcode in [31:21], second source in [20:16], first source in [9:5] and destination in [4:0]. The opcodes are 10001011000 (add), 11001011000 (subtract), 10001010000 (AND) and 10101010000 (OR). The destination gets the 64-bit result, modulo 2^64.
- R3: An instruction with [31:23]=110100101 writes to register [4:0] the value of bits [20:5], zero-extended.
- R4: Register 31 always reads as zero, and any write to it is discarded.
- R5: A load (opcode 11111000010) writes to register [4:0] the data-memory doubleword at address reg[9:5] plus the sign-extended bits [20:12]. The word index is address bits [3+:5], so the low three bits are ignored.
- R6: A store (opcode 11111000000) writes register [4:0] to data memory at the address computed as in R5. `st_valid`, `st_addr` and `st_data` show the store, and `wb_valid` stays 0.
- R7: An instruction with [31:24]=10110100 tests register [4:0]. If it is zero, PC becomes PC plus the sign-extended bits [23:5] times 4. Otherwise PC advances by 4.
- R8: An instruction with [31:26]=000101 sets PC to PC plus the sign-extended bits [25:0] times 4.
- R9: Any other encoding writes neither a register nor memory, and PC advances by 4.
- R10: Every non-branch instruction advances PC by 4. The instruction index is PC bits [7:2].
- R11: A load-stream beat writes `ld_data[31:0]` to instruction word `ld_addr` when `ld_sel` is 0, and writes `ld_data` to data doubleword `ld_addr` when `ld_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Execute when high; park at PC 0 when low |
| ld_valid | input | 1 | Load-stream word offered |
| ld_ready | output | 1 | Load stream accepts (core idle) |
| ld_sel | input | 1 | 0 = instruction memory, 1 = data memory |
| ld_addr | input | 6 | Word index for the load beat |
| ld_data | input | 64 | Load-beat payload |
| pc_o | output | 64 | Current program counter |
| wb_valid | output | 1 | Current instruction writes a register |
| wb_reg | output | 5 | Destination register |
| wb_data | output | 64 | Value being written back |
| st_valid | output | 1 | Current instruction stores |
| st_addr | output | 64 | Store byte address |
| st_data | output | 64 | Store data |

## Verification
A corrupted register value is not visible when it is written. It shows up at the ports on the next instruction that reads that register: in `wb_data` or `st_data` for that cycle, or in `pc_o` one edge later when a zero test reads it. A wrong PC shows in `pc_o` right after the faulty edge, and every later trace entry comes from the wrong instruction. A wrong memory word stays hidden until a later load returns it through `wb_data`, so each store in the test programs is followed by a load from the same address.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [10:0] OPC_LDUR = 11'b11111000010;
  localparam logic [10:0] OPC_STUR = 11'b11111000000;
  localparam logic [10:0] OPC_ADD  = 11'b10001011000;
  localparam logic [10:0] OPC_SUB  = 11'b11001011000;
  localparam logic [10:0] OPC_AND  = 11'b10001010000;
  localparam logic [10:0] OPC_ORR  = 11'b10101010000;
  localparam logic [7:0]  OPC_CBZ8  = 8'b10110100;
  localparam logic [5:0]  OPC_B6    = 6'b000101;
  localparam logic [8:0]  OPC_MOVZ9 = 9'b110100101;

  typedef enum logic [3:0] {
    ALU_AND   = 4'b0000,
    ALU_OR    = 4'b0001,
    ALU_ADD   = 4'b0010,
    ALU_SUB   = 4'b0110,
    ALU_PASSB = 4'b0111,
    ALU_NOR   = 4'b1100
  } alu_op_e;

  typedef enum logic [2:0] {
    IMM_NONE = 3'b000,
    IMM_WIDE = 3'b001,
    IMM_BR   = 3'b100,
    IMM_CB   = 3'b101,
    IMM_MEM  = 3'b111
  } imm_sel_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0,
    WB_MEM = 2'd1,
    WB_IMM = 2'd2
  } wb_src_e;

  typedef struct packed {
    logic     reg_we;
    logic     mem_we;
    logic     alu_src_imm;
    logic     rb_is_rt;
    logic     branch_cond;
    logic     branch_uncond;
    wb_src_e  wb_src;
    alu_op_e  alu_op;
    imm_sel_e imm_sel;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [10:0] opc,
  output ctrl_t       ctl
);

  always_comb begin
    ctl         = '0;
    ctl.wb_src  = WB_ALU;
    ctl.alu_op  = ALU_ADD;
    ctl.imm_sel = IMM_NONE;
    if (opc[10:5] == OPC_B6) begin
      ctl.branch_uncond = 1'b1;
      ctl.imm_sel       = IMM_BR;
    end else if (opc[10:3] == OPC_CBZ8) begin
      ctl.branch_cond = 1'b1;
      ctl.rb_is_rt    = 1'b1;
      ctl.alu_op      = ALU_PASSB;
      ctl.imm_sel     = IMM_CB;
    end else if (opc[10:2] == OPC_MOVZ9) begin
      ctl.reg_we  = 1'b1;
      ctl.wb_src  = WB_IMM;
      ctl.imm_sel = IMM_WIDE;
    end else begin
      case (opc)
        OPC_ADD: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_ADD; end
        OPC_SUB: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SUB; end
        OPC_AND: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_AND; end
        OPC_ORR: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_OR;  end
        OPC_LDUR: begin
          ctl.reg_we      = 1'b1;
          ctl.alu_src_imm = 1'b1;
          ctl.wb_src      = WB_MEM;
          ctl.imm_sel     = IMM_MEM;
        end
        OPC_STUR: begin
          ctl.mem_we      = 1'b1;
          ctl.alu_src_imm = 1'b1;
          ctl.rb_is_rt    = 1'b1;
          ctl.imm_sel     = IMM_MEM;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sc_immgen.sv
module sc_immgen
  import sc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [25:0]  field,
  input  imm_sel_e     sel,
  output logic [W-1:0] imm
);

  always_comb begin
    case (sel)
      IMM_WIDE: imm = {{(W-16){1'b0}}, field[20:5]};
      IMM_BR:   imm = {{(W-26){field[25]}}, field[25:0]};
      IMM_CB:   imm = {{(W-19){field[23]}}, field[23:5]};
      IMM_MEM:  imm = {{(W-9){field[20]}}, field[20:12]};
      default:  imm = '0;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_PASSB: y = b;
      ALU_NOR:   y = ~(a | b);
      default:   y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 64,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr [NRD],
  output logic [W-1:0]  rdata [NRD]
);

  localparam logic [AW-1:0] ZR = AW'(NREG - 1);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != ZR) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == ZR) ? '0 : regs[raddr[p]];
  end

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != ZR) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 32,
  localparam int IAW  = $clog2(IMEM_WORDS),
  localparam int DAW  = $clog2(DMEM_WORDS),
  localparam int LDAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic            ld_sel,
  input  logic [LDAW-1:0] ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc_o,
  output logic            wb_valid,
  output logic [4:0]      wb_reg,
  output logic [XLEN-1:0] wb_data,
  output logic            st_valid,
  output logic [XLEN-1:0] st_addr,
  output logic [XLEN-1:0] st_data
);

  logic [XLEN-1:0] pc_q;
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [31:0]     instr;
  ctrl_t           ctl;
  logic [XLEN-1:0] imm;
  logic [4:0]      rf_ra [2];
  logic [XLEN-1:0] rf_rd [2];
  logic [XLEN-1:0] alu_b, alu_y, mem_q, wb_val, pc_next;
  logic            alu_zero, taken, ld_fire, rf_we;

  assign instr = imem[pc_q[2 +: IAW]];

  sc_decode u_dec (.opc(instr[31:21]), .ctl(ctl));

  sc_immgen #(.W(XLEN)) u_imm (.field(instr[25:0]), .sel(ctl.imm_sel), .imm(imm));

  assign rf_ra[0] = instr[9:5];
  assign rf_ra[1] = ctl.rb_is_rt ? instr[4:0] : instr[20:16];
  assign rf_we    = run && ctl.reg_we;

  sc_regfile #(.W(XLEN), .NREG(32), .NRD(2)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(instr[4:0]),
    .wdata(wb_val), .raddr(rf_ra), .rdata(rf_rd)
  );

  assign alu_b = ctl.alu_src_imm ? imm : rf_rd[1];

  sc_alu #(.W(XLEN)) u_alu (
    .a(rf_rd[0]), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  assign mem_q = dmem[alu_y[3 +: DAW]];

  always_comb begin
    case (ctl.wb_src)
      WB_MEM:  wb_val = mem_q;
      WB_IMM:  wb_val = imm;
      default: wb_val = alu_y;
    endcase
  end

  assign taken   = ctl.branch_uncond || (ctl.branch_cond && alu_zero);
  assign pc_next = taken ? pc_q + {imm[XLEN-3:0], 2'b00} : pc_q + XLEN'(4);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pc_q <= '0;
    else                pc_q <= pc_next;
  end

  assign ld_ready = !run;
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data[31:0];
  end

  always_ff @(posedge clk) begin
    if (ld_fire && ld_sel)            dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (run && ctl.mem_we)       dmem[alu_y[3 +: DAW]]  <= rf_rd[1];
  end

  assign pc_o     = pc_q;
  assign wb_valid = rf_we;
  assign wb_reg   = instr[4:0];
  assign wb_data  = wb_val;
  assign st_valid = run && ctl.mem_we;
  assign st_addr  = alu_y;
  assign st_data  = rf_rd[1];

  a_r1_idle_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc_q == '0);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!wb_valid && !st_valid));
  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !wb_valid);
  a_r9_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.mem_we, ctl.reg_we, ctl.branch_cond, ctl.branch_uncond}));
  a_r10_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctl.branch_cond && !ctl.branch_uncond) |=> pc_q == $past(pc_q) + XLEN'(4));
  a_r7_cbz_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctl.branch_cond && rf_rd[1] != '0) |=> pc_q == $past(pc_q) + XLEN'(4));
  a_r2_sub_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.alu_op == ALU_SUB) |-> (alu_y + alu_b == rf_rd[0]));

endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;
  logic [63:0] pc_o, wb_data, st_addr, st_data;
  logic        wb_valid, st_valid;
  logic [4:0]  wb_reg;

  int total = 0;
  int bad = 0;
  logic [31:0] prog [64];

  always #4 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  function automatic logic [31:0] e_r(logic [10:0] op, logic [4:0] rd, logic [4:0] rn, logic [4:0] rm);
    return {op, rm, 6'd0, rn, rd};
  endfunction
  function automatic logic [31:0] e_d(logic [10:0] op, logic [4:0] rt, logic [4:0] rn, int off);
    logic [8:0] o = off[8:0];
    return {op, o, 2'b00, rn, rt};
  endfunction
  function automatic logic [31:0] e_cbz(logic [4:0] rt, int off);
    logic [18:0] o = off[18:0];
    return {8'b10110100, o, rt};
  endfunction
  function automatic logic [31:0] e_b(int off);
    logic [25:0] o = off[25:0];
    return {6'b000101, o};
  endfunction
  function automatic logic [31:0] e_mz(logic [4:0] rd, logic [15:0] v);
    return {9'b110100101, 2'b00, v, rd};
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic load_word(logic sel, int idx, logic [63:0] v);
    ld_valid = 1'b1; ld_sel = sel; ld_addr = idx[5:0]; ld_data = v;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic load_prog(int n);
    for (int i = 0; i <= n; i++) load_word(1'b0, i, {32'd0, prog[i]});
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
  endtask

  task automatic start_run();
    run = 1'b1;
    #1;
  endtask

  task automatic stop_run();
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R1 pc parked", pc_o, 64'd0);
    chk("R1 ld_ready idle", {63'd0, ld_ready}, 64'd1);
  endtask

  task automatic wb_chk(string req, logic [4:0] rd, logic [63:0] v);
    chk(req, {63'd0, wb_valid}, 64'd1);
    chk(req, {59'd0, wb_reg}, {59'd0, rd});
    chk(req, wb_data, v);
    chk(req, {63'd0, st_valid}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 got=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] vals [8];
    logic [63:0] dv [8];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h7fff;
    vals[4] = 16'h8000; vals[5] = 16'hffff; vals[6] = 16'h1234; vals[7] = 16'h00ff;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset / idle state
    chk("R1 reset pc", pc_o, 64'd0);
    chk("R1 reset wb_valid", {63'd0, wb_valid}, 64'd0);
    chk("R1 reset st_valid", {63'd0, st_valid}, 64'd0);
    chk("R1 reset ld_ready", {63'd0, ld_ready}, 64'd1);

    // R2 R3 R10 R11: sweep of operand pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [63:0] a, b;
        logic [4:0] rx, ry;
        a = {48'd0, vals[i]}; b = {48'd0, vals[j]};
        rx = 5'(1 + i); ry = 5'(9 + j);
        clear_prog();
        prog[0] = e_mz(rx, vals[i]);
        prog[1] = e_mz(ry, vals[j]);
        prog[2] = e_r(11'b10001011000, 5'd20, rx, ry);
        prog[3] = e_r(11'b11001011000, 5'd21, rx, ry);
        prog[4] = e_r(11'b10001010000, 5'd22, rx, ry);
        prog[5] = e_r(11'b10101010000, 5'd23, rx, ry);
        load_prog(6);
        start_run();
        chk("R1 ld_ready busy", {63'd0, ld_ready}, 64'd0);
        chk("R10 pc0", pc_o, 64'd0);
        wb_chk("R3 movz a", rx, a);
        @(negedge clk); chk("R10 pc1", pc_o, 64'd4);
        wb_chk("R3 movz b", ry, b);
        @(negedge clk); chk("R10 pc2", pc_o, 64'd8);
        wb_chk("R2 add", 5'd20, a + b);
        @(negedge clk); wb_chk("R2 sub", 5'd21, a - b);
        @(negedge clk); wb_chk("R2 and", 5'd22, a & b);
        @(negedge clk); chk("R10 pc5", pc_o, 64'd20);
        wb_chk("R2 orr", 5'd23, a | b);
        stop_run();
      end
    end

    // R4: zero register
    clear_prog();
    prog[0] = e_mz(5'd31, 16'd77);
    prog[1] = e_r(11'b10001011000, 5'd3, 5'd31, 5'd31);
    prog[2] = e_mz(5'd5, 16'd9);
    prog[3] = e_r(11'b10101010000, 5'd6, 5'd5, 5'd31);
    load_prog(4);
    start_run();
    @(negedge clk); wb_chk("R4 read zero after write", 5'd3, 64'd0);
    @(negedge clk);
    @(negedge clk); wb_chk("R4 or with zero reg", 5'd6, 64'd9);
    stop_run();

    // R5 R6 R11: memory path
    for (int k = 0; k < 8; k++) begin
      dv[k] = {32'hC0DE0000 + 32'(k), 32'h13579BDF ^ 32'(k * 7)};
      load_word(1'b1, k, dv[k]);
    end
    clear_prog();
    prog[0] = e_d(11'b11111000010, 5'd1, 5'd31, 24);
    prog[1] = e_mz(5'd2, 16'h00a5);
    prog[2] = e_d(11'b11111000000, 5'd2, 5'd31, 80);
    prog[3] = e_mz(5'd9, 16'd64);
    prog[4] = e_d(11'b11111000000, 5'd1, 5'd9, -16);
    prog[5] = e_d(11'b11111000010, 5'd3, 5'd9, 16);
    prog[6] = e_d(11'b11111000010, 5'd4, 5'd31, 48);
    prog[7] = e_d(11'b11111000010, 5'd5, 5'd31, 86);
    for (int k = 0; k < 8; k++) prog[8 + k] = e_d(11'b11111000010, 5'(12 + k), 5'd31, k * 8);
    load_prog(16);
    start_run();
    wb_chk("R11 R5 preloaded word", 5'd1, dv[3]);
    @(negedge clk);
    @(negedge clk);
    chk("R6 st_valid", {63'd0, st_valid}, 64'd1);
    chk("R6 st_addr", st_addr, 64'd80);
    chk("R6 st_data", st_data, 64'h00a5);
    chk("R6 no wb", {63'd0, wb_valid}, 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R6 neg offset addr", st_addr, 64'd48);
    chk("R6 neg offset data", st_data, dv[3]);
    @(negedge clk); wb_chk("R5 load back stored", 5'd3, 64'h00a5);
    @(negedge clk); wb_chk("R5 load second store", 5'd4, dv[3]);
    @(negedge clk); wb_chk("R5 low bits ignored", 5'd5, 64'h00a5);
    for (int k = 0; k < 8; k++) begin
      logic [63:0] e;
      e = (k == 6) ? dv[3] : dv[k];
      @(negedge clk); wb_chk("R5 sweep", 5'(12 + k), e);
    end
    stop_run();

    // R7 R8 R9: control flow
    clear_prog();
    prog[0]  = e_mz(5'd1, 16'd0);
    prog[1]  = e_mz(5'd2, 16'd5);
    prog[2]  = e_cbz(5'd2, 5);
    prog[3]  = e_cbz(5'd1, 3);
    prog[4]  = e_mz(5'd10, 16'd1);
    prog[5]  = e_mz(5'd10, 16'd2);
    prog[6]  = e_b(4);
    prog[7]  = e_cbz(5'd31, 5);
    prog[10] = e_b(-3);
    prog[13] = e_mz(5'd11, 16'h4321);
    load_prog(14);
    start_run();
    @(negedge clk);
    @(negedge clk);
    chk("R7 cbz nonzero no wb", {63'd0, wb_valid}, 64'd0);
    @(negedge clk); chk("R7 not taken pc", pc_o, 64'd12);
    @(negedge clk); chk("R7 taken fwd pc", pc_o, 64'd24);
    chk("R8 b no wb", {63'd0, wb_valid}, 64'd0);
    @(negedge clk); chk("R8 fwd pc", pc_o, 64'd40);
    @(negedge clk); chk("R8 back pc", pc_o, 64'd28);
    @(negedge clk); chk("R7 zero reg taken pc", pc_o, 64'd48);
    chk("R9 unknown no wb", {63'd0, wb_valid}, 64'd0);
    chk("R9 unknown no st", {63'd0, st_valid}, 64'd0);
    @(negedge clk); chk("R9 unknown pc+4", pc_o, 64'd52);
    wb_chk("R9 next runs", 5'd11, 64'h4321);
    stop_run();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule